// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a bus-mapped interval timer. Software loads a start count into a set buffer, picks one of four externally generated tick sources and a count direction, and sets the run bit. Each rising edge of the chosen tick source moves a 16-bit counter by one. When the counter steps onto zero, the timer has expired. It then sets a done flag, or an overrun flag if done is still set from an earlier expiry. It raises an interrupt request if enabled. In repeat mode it reloads the counter from the buffer. In single mode it stops.

The tick inputs are asynchronous to the system clock. Each one is synchronised and edge-detected, so a tick is counted once however long it stays high. While the timer is stopped, software can advance the counter by hand, one tick per control write. The tick sources are 100 kHz, 10 kHz, line frequency and an external 10 Hz signal. They are produced outside the block.

Top module: `ivl_timer`

## Requirements
- R1: After reset the control word, set buffer, live counter and interrupt request all read zero.
- R2: bus_addr[2:1] selects the register: 0 control/status, 1 set buffer, 2 live counter, 3 reads zero. Writes to the live counter or to select 3 change no state.
- R3: A control write stores run (bit 0), repeat (bit 1), rate (bits 3:2), up (bit 4) and interrupt enable (bit 6). It clears done (bit 7), overrun (bit 15) and the interrupt request. Bit 5 (step) always reads zero.
- R4: A set buffer write loads both the buffer and the counter. It clears done, overrun and the interrupt request.
- R5: While running, each rising edge of tick_in[rate] moves the counter once. The other tick inputs have no effect, and nothing counts while run is clear.
- R6: With up set the counter increments and expires on the wrap from all-ones to zero. With up clear it decrements and expires on reaching zero.
- R7: On expiry, done is set if it was clear. If done was already set, overrun is set instead.
- R8: On expiry with interrupt enable set, irq goes high and stays high until the next control or set buffer write. Without enable, irq stays low.
- R9: On expiry in repeat mode the counter reloads from the set buffer and run stays set.
- R10: On expiry in single mode the counter stays at zero, the set buffer is cleared and run is cleared.
- R11: A control write with run clear and step set moves the counter once, in the direction given by the written up bit. If that reaches zero, expiry handling runs. Step is ignored when the write sets run.
- R12: The counter reloads from the set buffer when run goes from 0 to 1, or when the rate changes while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word select, address bits 2:1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| tick_in | input | 4 | Asynchronous tick sources, indexed by rate |
| irq | output | 1 | Interrupt request level |

## Verification
Some invariants are checked on every cycle. Overrun is never set without done. A rising irq requires interrupt enable. Every expiry leaves the timer either in repeat mode or stopped with an empty buffer. Writes to the live counter never move it. Each synchronised tick edge lasts one cycle. Only the bench's scenarios can show the rest: source selection, direction and wrap points, when overrun appears relative to done, restart on a run or rate change, and manual stepping, since each depends on a sequence of writes and tick edges.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
    localparam int CNT_W  = 16;
    localparam int RATE_W = 2;
    localparam int NSRC   = 1 << RATE_W;

    localparam int B_GO   = 0;
    localparam int B_RPT  = 1;
    localparam int B_RATE = 2;
    localparam int B_UP   = B_RATE + RATE_W;
    localparam int B_STEP = B_UP + 1;
    localparam int B_IE   = B_STEP + 1;
    localparam int B_DONE = B_IE + 1;
    localparam int B_ERR  = CNT_W - 1;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_BUF  = 2'd1,
        REG_LIVE = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              go;
        logic              rpt;
        logic [RATE_W-1:0] rate;
        logic              up;
        logic              ie;
        logic              done;
        logic              err;
        logic              irq;
        logic [CNT_W-1:0]  setv;
        logic [CNT_W-1:0]  cnt;
    } tmr_state_t;
endpackage

// File: rtl/ivl_tick_sync.sv
module ivl_tick_sync #(
    parameter int NSRC   = 4,
    parameter int STAGES = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [NSRC-1:0] rise;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [STAGES:0] sh_q;
        logic [STAGES:0] sh_d;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], src_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise[i] = sh_q[STAGES-1] & ~sh_q[STAGES];

        // R5: one tick edge produces exactly one counting pulse
        assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end

    assign tick = rise[sel];
endmodule

// File: rtl/ivl_step.sv
module ivl_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt,
    output logic         zero
);
    always_comb begin
        nxt  = up ? cur + W'(1) : cur - W'(1);
        zero = (nxt == '0);
    end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [2:1]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NSRC-1:0]   tick_in,
    output logic              irq
);
    tmr_state_t       st_q, st_d;
    logic             tick_pls;
    logic             wr_ctl, wr_buf, tick_go, do_step, expire_w, step_up;
    logic [CNT_W-1:0] step_nxt;
    logic             step_zero;
    reg_sel_e         rsel;

    assign rsel = reg_sel_e'(bus_addr);

    ivl_tick_sync #(.NSRC(NSRC), .STAGES(2)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (tick_in),
        .sel    (st_q.rate),
        .tick   (tick_pls)
    );

    assign wr_ctl  = bus_wen && (rsel == REG_CTL);
    assign wr_buf  = bus_wen && (rsel == REG_BUF);
    assign tick_go = tick_pls && st_q.go && !bus_wen;
    assign step_up = wr_ctl ? bus_wdata[B_UP] : st_q.up;

    ivl_step #(.W(CNT_W)) step_i (
        .cur  (st_q.cnt),
        .up   (step_up),
        .nxt  (step_nxt),
        .zero (step_zero)
    );

    always_comb begin
        st_d     = st_q;
        expire_w = 1'b0;
        do_step  = tick_go || (wr_ctl && !bus_wdata[B_GO] && bus_wdata[B_STEP]);

        if (wr_buf) begin
            st_d.setv = bus_wdata;
            st_d.cnt  = bus_wdata;
            st_d.done = 1'b0;
            st_d.err  = 1'b0;
            st_d.irq  = 1'b0;
        end else if (wr_ctl) begin
            st_d.go   = bus_wdata[B_GO];
            st_d.rpt  = bus_wdata[B_RPT];
            st_d.rate = bus_wdata[B_RATE +: RATE_W];
            st_d.up   = bus_wdata[B_UP];
            st_d.ie   = bus_wdata[B_IE];
            st_d.done = 1'b0;
            st_d.err  = 1'b0;
            st_d.irq  = 1'b0;
            if (st_d.go && (!st_q.go || st_d.rate != st_q.rate))
                st_d.cnt = st_q.setv;
        end

        if (do_step) begin
            st_d.cnt = step_nxt;
            expire_w = step_zero;
        end

        if (expire_w) begin
            if (st_d.done) st_d.err  = 1'b1;
            else           st_d.done = 1'b1;
            if (st_d.ie)   st_d.irq  = 1'b1;
            if (st_d.rpt) begin
                st_d.cnt = st_d.setv;
            end else begin
                st_d.setv = '0;
                st_d.go   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            REG_CTL: begin
                bus_rdata[B_GO]                = st_q.go;
                bus_rdata[B_RPT]               = st_q.rpt;
                bus_rdata[B_RATE +: RATE_W]    = st_q.rate;
                bus_rdata[B_UP]                = st_q.up;
                bus_rdata[B_IE]                = st_q.ie;
                bus_rdata[B_DONE]              = st_q.done;
                bus_rdata[B_ERR]               = st_q.err;
            end
            REG_BUF:  bus_rdata = st_q.setv;
            REG_LIVE: bus_rdata = st_q.cnt;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = st_q.irq;

    // R7: overrun only ever accompanies a set done flag
    assert_err_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> st_q.done);

    // R8: a new interrupt request requires the enable
    assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> st_q.ie);

    // R10: after expiry the timer either repeats or is stopped with an empty buffer
    assert_single_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire_w |=> (st_q.rpt || (!st_q.go && st_q.setv == '0)));

    // R2: the live counter ignores writes
    assert_live_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && rsel == REG_LIVE) |=> $stable(st_q.cnt));
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [2:1]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  tick_in = '0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    ivl_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in), .irq(irq)
    );

    // control bit values
    localparam logic [15:0] GO = 16'h0001, RPT = 16'h0002, UP = 16'h0010,
                            STEP = 16'h0020, IE = 16'h0040, DONE = 16'h0080,
                            ERR = 16'h8000;
    function automatic logic [15:0] rate(input int r);
        return 16'(r << 2);
    endfunction

    // vector: wr, sel, data, expected read
    localparam int NV = 10;
    localparam logic [34:0] VEC [0:NV-1] = '{
        {1'b1, 2'd1, 16'h1234, 16'h0000},
        {1'b0, 2'd1, 16'h0000, 16'h1234},
        {1'b0, 2'd2, 16'h0000, 16'h1234},
        {1'b1, 2'd2, 16'hFFFF, 16'h0000},
        {1'b0, 2'd2, 16'h0000, 16'h1234},
        {1'b1, 2'd3, 16'hFFFF, 16'h0000},
        {1'b0, 2'd3, 16'h0000, 16'h0000},
        {1'b1, 2'd0, 16'hFFFF, 16'h0000},
        {1'b0, 2'd0, 16'h0000, 16'h005F},
        {1'b0, 2'd1, 16'h0000, 16'h1234}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = s; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] s, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = s;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        tick_in[s] = 1'b1;
        repeat (3) @(negedge clk);
        tick_in[s] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 ctl", 2'd0, 16'h0);
        rd("R1 buf", 2'd1, 16'h0);
        rd("R1 cnt", 2'd2, 16'h0);
        check("R1 irq", 16'(irq), 16'h0);

        // R2 R3 R4 register map via vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][34]) wr(VEC[i][33:32], VEC[i][31:16]);
            else rd("R2/R3/R4 vector", VEC[i][33:32], VEC[i][15:0]);
        end
        wr(2'd0, 16'h0);
        rd("R3 ctl cleared", 2'd0, 16'h0);

        // down count, single mode, rate 1 (R5 R6 R7 R8 R10)
        wr(2'd1, 16'd3);
        wr(2'd0, GO | IE | rate(1));
        pulse(0);
        rd("R5 other source ignored", 2'd2, 16'd3);
        pulse(1);
        pulse(1);
        rd("R6 down count", 2'd2, 16'd1);
        check("R8 no irq yet", 16'(irq), 16'h0);
        pulse(1);
        rd("R10 counter zero", 2'd2, 16'd0);
        rd("R7 R10 done set, go clear", 2'd0, IE | rate(1) | DONE);
        rd("R10 buffer cleared", 2'd1, 16'd0);
        check("R8 irq raised", 16'(irq), 16'h1);
        pulse(1);
        rd("R5 stopped no count", 2'd2, 16'd0);
        wr(2'd0, IE);
        check("R3 irq cleared", 16'(irq), 16'h0);
        rd("R3 done cleared", 2'd0, IE);

        // up count, repeat, rate 2, overrun (R6 R7 R9 R8)
        wr(2'd1, 16'hFFFE);
        wr(2'd0, GO | RPT | UP | rate(2));
        pulse(2);
        rd("R6 up count", 2'd2, 16'hFFFF);
        pulse(2);
        rd("R9 reload", 2'd2, 16'hFFFE);
        rd("R7 done after wrap", 2'd0, GO | RPT | UP | rate(2) | DONE);
        check("R8 no irq without enable", 16'(irq), 16'h0);
        pulse(2);
        pulse(2);
        rd("R7 overrun", 2'd0, GO | RPT | UP | rate(2) | DONE | ERR);
        rd("R9 buffer kept", 2'd1, 16'hFFFE);
        wr(2'd1, 16'd5);
        rd("R4 flags cleared", 2'd0, GO | RPT | UP | rate(2));
        rd("R4 counter loaded", 2'd2, 16'd5);

        // restart rules (R12)
        pulse(2);
        rd("R12 counted", 2'd2, 16'd6);
        wr(2'd0, GO | RPT | UP | rate(3));
        rd("R12 rate change reload", 2'd2, 16'd5);
        pulse(3);
        rd("R5 new source", 2'd2, 16'd6);
        wr(2'd0, 16'h0);
        rd("R12 stop keeps count", 2'd2, 16'd6);
        wr(2'd0, GO | RPT | UP | rate(3));
        rd("R12 go rise reload", 2'd2, 16'd5);

        // single step (R11)
        wr(2'd0, 16'h0);
        wr(2'd1, 16'd2);
        wr(2'd0, STEP);
        rd("R11 step down", 2'd2, 16'd1);
        rd("R3 step reads zero", 2'd0, 16'h0);
        wr(2'd0, STEP | IE);
        rd("R11 step expiry", 2'd0, IE | DONE);
        check("R11 irq on step expiry", 16'(irq), 16'h1);
        rd("R11 single clears buffer", 2'd1, 16'd0);
        wr(2'd1, 16'hFFFF);
        wr(2'd0, STEP | UP);
        rd("R11 step up wraps", 2'd2, 16'd0);
        rd("R11 done after up step", 2'd0, UP | DONE);
        check("R11 irq clear without enable", 16'(irq), 16'h0);
        wr(2'd1, 16'd7);
        wr(2'd0, GO | STEP);
        rd("R11 step ignored while running", 2'd2, 16'd7);

        summary();
    end
endmodule